// File: doc/BRIEF.md
# Dual-Width Pixel Output Formatter

This block takes a stream of processed pixel samples and presents them on a 10-pin output bus. Each sample carries a 10-bit value, an out-of-range flag, a per-pixel valid bit from the coefficient path and a channel index. A new sample is announced by a one-cycle `pix_strobe`. In wide mode the whole value appears on the bus at once. In byte mode each pixel takes two slots on the upper eight pins. The first slot is announced by `pix_strobe` and the second by `half_strobe`. The second slot carries the two low data bits and the out-of-range flag.

An active-low data-valid output marks the samples chosen as valid. The valid bit comes either from the coefficient path or from a per-channel mask, so a user can, for example, keep only red pixels. A hold option freezes the bus, the flag and the colour code between valid samples. A 3-bit colour code names the channel of the sample on the bus and the half-pixel slot. One enable input releases every output through a registered pad-enable signal. All outputs are registered, and reset is synchronous and active high.

Top module: `pix_out_fmt`

## Requirements
- R1: While `rst` is sampled high, the registered outputs settle to: `out_bus`=0, `out_dv_n`=1, `out_ovr`=0, `out_cc`=000 and `pad_oe`=0.
- R2: With `cfg_byte_mode`=0, a sample taken on a `pix_strobe` edge appears on `out_bus` after that edge, with all ten bits unchanged. `half_strobe` has no effect in this mode.
- R3: With `cfg_byte_mode`=1, a `pix_strobe` edge loads the first slot: `out_bus[9:2]` = d[9:2], `out_bus[1:0]`=0 and `out_cc` = {chan, 0}. In wide mode `out_cc` = {chan, 0} as well.
- R4: With `cfg_byte_mode`=1, a `half_strobe` edge without `pix_strobe` loads the second slot of the last pixel. `out_bus[9:2]` = {d1, d0, 00000, ovr}, `out_bus[1:0]`=0 and `out_cc` = {chan, 1}.
- R5: `out_ovr` shows the out-of-range flag of the pixel whose data is on the bus, in both slots and in both modes.
- R6: Each `pix_strobe` edge sets `out_dv_n` to 0 if the sample is valid and to 1 if it is not. Between `pix_strobe` edges, `out_dv_n` keeps its value, through the second slot as well.
- R7: With `cfg_valid_src`=1, the valid bit is `pix_valid_ext`. With `cfg_valid_src`=0, it is `cfg_valid_mask[chan]`, where channel codes are R=0, G=1 and B=2. Channel code 3 is never valid from the mask.
- R8: With `cfg_hold`=0, the bus, flag and code update on every loaded slot. With `cfg_hold`=1 they update only for slots of a valid pixel and otherwise keep their previous value. `out_dv_n` still follows R6.
- R9: `pad_oe` equals the inverse of `oe_n` as sampled on the previous edge. When it is 0, all of `out_bus`, `out_dv_n`, `out_ovr` and `out_cc` are meant to be high impedance at the pads.
- R10: On an edge with neither strobe, or with only `half_strobe` in wide mode, `out_bus`, `out_ovr` and `out_cc` do not change.
- R11: When both strobes are high on the same edge, `pix_strobe` wins and the first slot of the new pixel is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_strobe | input | 1 | New pixel sample present this cycle |
| half_strobe | input | 1 | Second-slot tick in byte mode |
| pix_data | input | 10 | Processed pixel value |
| pix_ovr | input | 1 | Out-of-range flag of the sample |
| pix_valid_ext | input | 1 | Valid bit carried with the coefficients |
| pix_chan | input | 2 | Channel index: R=0, G=1, B=2 |
| cfg_byte_mode | input | 1 | 0: wide 10-bit, 1: two bytes per pixel |
| cfg_hold | input | 1 | Hold the bus between valid pixels |
| cfg_valid_src | input | 1 | 1: external valid bit, 0: channel mask |
| cfg_valid_mask | input | 3 | Per-channel valid default |
| oe_n | input | 1 | Output enable, active low |
| out_bus | output | 10 | Output data bus |
| out_dv_n | output | 1 | Data valid, active low |
| out_ovr | output | 1 | Out-of-range flag |
| out_cc | output | 3 | Colour code {chan, slot} |
| pad_oe | output | 1 | Pad drive enable for all outputs |

## Verification
On every cycle the assertions check several stable-state rules. Without a load, the bus, flag and code stay fixed. `out_dv_n` changes only on a pixel strobe. An invalid sample drives it high. A held slot leaves the bus untouched, the byte-mode lower pins stay zero, and the pad enable follows the enable input by one edge. Only the bench's scenarios can show the actual values, because they are compared with an independent model on every clock. These include the byte packing of both slots, the choice of the valid source and mask, the pixel held across invalid samples, and strobe collisions under random mode changes.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int CHAN_W = 2;
  localparam int NUM_CH = 3;
  localparam int CC_W   = CHAN_W + 1;

  typedef enum logic [CHAN_W-1:0] {
    CH_RED  = 2'd0,
    CH_GRN  = 2'd1,
    CH_BLU  = 2'd2,
    CH_NONE = 2'd3
  } chan_e;

  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } slot_e;
endpackage

// File: rtl/pof_valid_sel.sv
module pof_valid_sel
  import pof_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic              ext_valid,
  input  logic              use_ext,
  input  logic [NCH-1:0]    mask,
  output logic              valid
);
  logic [(1<<CHAN_W)-1:0] mask_ext;

  genvar g;
  generate
    for (g = 0; g < (1 << CHAN_W); g++) begin : g_mask
      if (g < NCH) begin : g_used
        assign mask_ext[g] = mask[g];
      end else begin : g_rsv
        assign mask_ext[g] = 1'b0;
      end
    end
  endgenerate

  assign valid = use_ext ? ext_valid : mask_ext[chan];
endmodule

// File: rtl/pof_lane_pack.sv
module pof_lane_pack #(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              ovr,
  input  logic              byte_mode,
  input  logic              second,
  output logic [DATA_W-1:0] word
);
  localparam int LOW_W = DATA_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LOW_W - 1;

  logic [BYTE_W-1:0] tail_byte;

  generate
    if (PAD_W > 0) begin : g_pad
      assign tail_byte = {data[LOW_W-1:0], {PAD_W{1'b0}}, ovr};
    end else begin : g_nopad
      assign tail_byte = {data[LOW_W-1:0], ovr};
    end
  endgenerate

  always_comb begin
    if (!byte_mode)
      word = data;
    else if (!second)
      word = {data[DATA_W-1:LOW_W], {LOW_W{1'b0}}};
    else
      word = {tail_byte, {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/pof_out_stage.sv
module pof_out_stage
  import pof_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic              load,
  input  logic              upd,
  input  logic              new_pix,
  input  logic              valid,
  input  logic [DATA_W-1:0] word,
  input  logic              ovr,
  input  logic [CC_W-1:0]   cc,
  output logic [DATA_W-1:0] bus_q,
  output logic              dv_n_q,
  output logic              ovr_q,
  output logic [CC_W-1:0]   cc_q,
  output logic              pad_oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q    <= '0;
      dv_n_q   <= 1'b1;
      ovr_q    <= 1'b0;
      cc_q     <= '0;
      pad_oe_q <= 1'b0;
    end else begin
      pad_oe_q <= !oe_n;
      if (new_pix)
        dv_n_q <= !valid;
      if (load && upd) begin
        bus_q <= word;
        ovr_q <= ovr;
        cc_q  <= cc;
      end
    end
  end

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(bus_q) && $stable(ovr_q) && $stable(cc_q)));

  // R6
  dv_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !new_pix |=> $stable(dv_n_q));

  // R6
  dv_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (new_pix && !valid) |=> dv_n_q);

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !upd) |=> $stable(bus_q));

  // R9
  pad_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_oe_q == !$past(oe_n)));
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pof_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_strobe,
  input  logic              half_strobe,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_ovr,
  input  logic              pix_valid_ext,
  input  logic [CHAN_W-1:0] pix_chan,
  input  logic              cfg_byte_mode,
  input  logic              cfg_hold,
  input  logic              cfg_valid_src,
  input  logic [NUM_CH-1:0] cfg_valid_mask,
  input  logic              oe_n,
  output logic [DATA_W-1:0] out_bus,
  output logic              out_dv_n,
  output logic              out_ovr,
  output logic [CC_W-1:0]   out_cc,
  output logic              pad_oe
);
  localparam int LOW_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] cap_data;
  logic              cap_ovr;
  logic [CHAN_W-1:0] cap_chan;
  logic              cap_valid;

  logic              in_valid;
  logic              sel_second;
  logic [DATA_W-1:0] sel_data;
  logic              sel_ovr;
  logic [CHAN_W-1:0] sel_chan;
  logic              sel_valid;
  logic              load;
  logic              upd;
  logic [DATA_W-1:0] word;
  logic [CC_W-1:0]   cc_next;

  pof_valid_sel #(.NCH(NUM_CH)) u_vsel (
    .chan      (pix_chan),
    .ext_valid (pix_valid_ext),
    .use_ext   (cfg_valid_src),
    .mask      (cfg_valid_mask),
    .valid     (in_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data  <= '0;
      cap_ovr   <= 1'b0;
      cap_chan  <= '0;
      cap_valid <= 1'b0;
    end else if (pix_strobe) begin
      cap_data  <= pix_data;
      cap_ovr   <= pix_ovr;
      cap_chan  <= pix_chan;
      cap_valid <= in_valid;
    end
  end

  always_comb begin
    sel_second = !pix_strobe;
    sel_data   = pix_strobe ? pix_data : cap_data;
    sel_ovr    = pix_strobe ? pix_ovr  : cap_ovr;
    sel_chan   = pix_strobe ? pix_chan : cap_chan;
    sel_valid  = pix_strobe ? in_valid : cap_valid;
    load       = pix_strobe || (half_strobe && cfg_byte_mode);
    upd        = !cfg_hold || sel_valid;
    cc_next    = {sel_chan, (cfg_byte_mode && sel_second) ? SLOT_SECOND : SLOT_FIRST};
  end

  pof_lane_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pack (
    .data      (sel_data),
    .ovr       (sel_ovr),
    .byte_mode (cfg_byte_mode),
    .second    (sel_second),
    .word      (word)
  );

  pof_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .oe_n     (oe_n),
    .load     (load),
    .upd      (upd),
    .new_pix  (pix_strobe),
    .valid    (in_valid),
    .word     (word),
    .ovr      (sel_ovr),
    .cc       (cc_next),
    .bus_q    (out_bus),
    .dv_n_q   (out_dv_n),
    .ovr_q    (out_ovr),
    .cc_q     (out_cc),
    .pad_oe_q (pad_oe)
  );

  // R3
  byte_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (load && upd && cfg_byte_mode) |=> (out_bus[LOW_W-1:0] == '0));

  // R11
  strobe_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_strobe && half_strobe && upd) |=> (out_cc[0] == 1'b0));
endmodule

// File: tb/sim_pix_out_fmt.sv
`timescale 1ns/1ps
module sim_pix_out_fmt;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_strobe = 0, half_strobe = 0;
  logic [9:0] pix_data = '0;
  logic       pix_ovr = 0, pix_valid_ext = 0;
  logic [1:0] pix_chan = '0;
  logic       cfg_byte_mode = 0, cfg_hold = 0, cfg_valid_src = 0;
  logic [2:0] cfg_valid_mask = 3'b111;
  logic       oe_n = 1'b1;
  logic [9:0] out_bus;
  logic       out_dv_n, out_ovr, pad_oe;
  logic [2:0] out_cc;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;

  // reference model state
  logic [9:0] m_bus = '0;
  logic       m_dv_n = 1, m_ovr = 0, m_pad = 0;
  logic [2:0] m_cc = '0;
  logic [9:0] m_d = '0;
  logic       m_o = 0, m_v = 0;
  logic [1:0] m_ch = '0;
  string      m_tag = "R1";

  always #10 clk = ~clk;

  pix_out_fmt u0 (
    .clk(clk), .rst(rst), .pix_strobe(pix_strobe), .half_strobe(half_strobe),
    .pix_data(pix_data), .pix_ovr(pix_ovr), .pix_valid_ext(pix_valid_ext),
    .pix_chan(pix_chan), .cfg_byte_mode(cfg_byte_mode), .cfg_hold(cfg_hold),
    .cfg_valid_src(cfg_valid_src), .cfg_valid_mask(cfg_valid_mask), .oe_n(oe_n),
    .out_bus(out_bus), .out_dv_n(out_dv_n), .out_ovr(out_ovr), .out_cc(out_cc),
    .pad_oe(pad_oe)
  );

  function automatic logic want_valid(input logic src, input logic ext,
                                      input logic [2:0] mask, input logic [1:0] ch);
    if (src) return ext;
    if (ch == 2'd3) return 1'b0;
    return mask[ch];
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_bus = '0; m_dv_n = 1; m_ovr = 0; m_cc = '0; m_pad = 0;
      m_d = '0; m_o = 0; m_v = 0; m_ch = '0; m_tag = "R1";
    end else begin
      m_pad = !oe_n;
      if (pix_strobe) begin
        m_d = pix_data; m_o = pix_ovr; m_ch = pix_chan;
        m_v = want_valid(cfg_valid_src, pix_valid_ext, cfg_valid_mask, pix_chan);
        m_dv_n = !m_v;
        if (!cfg_hold || m_v) begin
          m_bus = cfg_byte_mode ? {m_d[9:2], 2'b00} : m_d;
          m_ovr = m_o;
          m_cc = {m_ch, 1'b0};
          m_tag = cfg_byte_mode ? "R3" : "R2";
        end else m_tag = "R8";
      end else if (half_strobe && cfg_byte_mode) begin
        if (!cfg_hold || m_v) begin
          m_bus = {m_d[1], m_d[0], 5'b00000, m_o, 2'b00};
          m_ovr = m_o;
          m_cc = {m_ch, 1'b1};
          m_tag = "R4";
        end else m_tag = "R8";
      end else m_tag = "R10";
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(m_tag, 32'(out_bus), 32'(m_bus));
      chk("R6", 32'(out_dv_n), 32'(m_dv_n));
      chk("R5", 32'(out_ovr), 32'(m_ovr));
      chk("R3", 32'(out_cc), 32'(m_cc));
      chk("R9", 32'(pad_oe), 32'(m_pad));
    end
  end

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  task automatic step;
    @(negedge clk);
  endtask

  // full pixel: first slot, gap, second slot, gap
  task automatic pixel(input logic [9:0] d, input logic o, input logic e, input logic [1:0] c);
    step();
    pix_strobe = 1; pix_data = d; pix_ovr = o; pix_valid_ext = e; pix_chan = c;
    step();
    pix_strobe = 0; pix_data = $urandom; pix_ovr = $urandom; pix_chan = $urandom;
    step();
    half_strobe = 1;
    step();
    half_strobe = 0;
  endtask

  initial begin
    step(); step(); step();
    // R1 reset values
    chk("R1", 32'(out_bus), 0);
    chk("R1", 32'(out_dv_n), 1);
    chk("R1", 32'(out_cc), 0);
    chk("R1", 32'(pad_oe), 0);
    rst = 0; oe_n = 0;

    // R2 wide mode
    for (int i = 0; i < 20; i++) pixel(10'($urandom), 1'($urandom), 0, 2'($urandom_range(0, 2)));
    step(); pix_strobe = 1; pix_data = 10'h2D5; pix_ovr = 1; pix_chan = 2'd1;
    step(); pix_strobe = 0;
    chk("R2", 32'(out_bus), 32'h2D5);
    chk("R5", 32'(out_ovr), 1);
    half_strobe = 1; step(); half_strobe = 0;
    chk("R2", 32'(out_bus), 32'h2D5);
    chk("R10", 32'(out_cc), 32'b010);

    // R3 R4 byte mode packing
    cfg_byte_mode = 1;
    step(); pix_strobe = 1; pix_data = 10'h2D5; pix_ovr = 1; pix_chan = 2'd2;
    step(); pix_strobe = 0;
    chk("R3", 32'(out_bus), 32'h2D4);
    chk("R3", 32'(out_cc), 32'b100);
    half_strobe = 1; step(); half_strobe = 0;
    chk("R4", 32'(out_bus), 32'h104);
    chk("R4", 32'(out_cc), 32'b101);
    chk("R5", 32'(out_ovr), 1);
    for (int i = 0; i < 20; i++) pixel(10'($urandom), 1'($urandom), 0, 2'($urandom_range(0, 2)));

    // R11 both strobes together
    step(); pix_strobe = 1; half_strobe = 1; pix_data = 10'h3FF; pix_ovr = 0; pix_chan = 2'd0;
    step(); pix_strobe = 0; half_strobe = 0;
    chk("R11", 32'(out_bus), 32'h3FC);
    chk("R11", 32'(out_cc), 32'b000);

    // R7 mask selects red only, then external source
    cfg_valid_mask = 3'b001;
    for (int c = 0; c < 4; c++) begin
      step(); pix_strobe = 1; pix_chan = 2'(c); pix_valid_ext = 1;
      step(); pix_strobe = 0;
      chk("R7", 32'(out_dv_n), (c == 0) ? 0 : 1);
    end
    cfg_valid_src = 1;
    for (int i = 0; i < 20; i++) pixel(10'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
    step(); pix_strobe = 1; pix_valid_ext = 1; pix_chan = 2'd2;
    step(); pix_strobe = 0;
    chk("R7", 32'(out_dv_n), 0);

    // R8 hold: red valid, others held
    cfg_valid_src = 0; cfg_hold = 1; cfg_byte_mode = 0;
    pixel(10'h155, 0, 0, 2'd0);
    pixel(10'h0AA, 1, 0, 2'd1);
    chk("R8", 32'(out_bus), 32'h155);
    chk("R8", 32'(out_dv_n), 1);
    cfg_byte_mode = 1;
    for (int i = 0; i < 20; i++) pixel(10'($urandom), 1'($urandom), 0, 2'($urandom));

    // R9 output enable
    oe_n = 1; step(); step();
    chk("R9", 32'(pad_oe), 0);
    oe_n = 0; step(); step();
    chk("R9", 32'(pad_oe), 1);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      step();
      pix_strobe = ($urandom_range(0, 3) == 0);
      half_strobe = ($urandom_range(0, 3) == 0);
      pix_data = $urandom; pix_ovr = $urandom; pix_valid_ext = $urandom; pix_chan = $urandom;
      oe_n = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 63) == 0) begin
        cfg_byte_mode = $urandom; cfg_hold = $urandom;
        cfg_valid_src = $urandom; cfg_valid_mask = $urandom;
      end
      rst = ($urandom_range(0, 999) == 0);
    end
    step(); rst = 0; pix_strobe = 0; half_strobe = 0;
    step(); step();
    finish_run();
  end
endmodule